// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Controller

This block turns level changes on a bank of already synchronized port pins into interrupt requests. Every pin has its own enable bit. The pins are split into equal contiguous groups, and each group feeds one interrupt vector. Each vector has its own edge polarity, rising or falling, and its own pending request latch. An edge on a pin counts as qualified when three things hold: the pin is enabled, the port reports the pin in input mode, and the edge matches the polarity of the pin's vector. A qualified edge on any pin of a group sets that group's request.

The processor side clears a request with a one-cycle acknowledge, which stands for the vector fetch. A small register port writes and reads back the pin enable mask and the per-vector polarity bits. Any write to the polarity bits discards every pending request. Arbitration between vectors is left to the interrupt controller downstream.

Top module: `pin_edge_irq`

## Requirements
- R1: After a synchronous active-low reset, all pin enables read 0, all polarity bits read 0 (falling), and every request output is 0.
- R2: A write with `wr_sel`=0 loads the pin enable mask (bit p = pin p). A write with `wr_sel`=1 loads the polarity bits (bit v = vector v, 1 = rising, 0 = falling). `rd_data` shows the register chosen by `rd_sel` (0 = enables, 1 = polarity, zero-extended), starting the cycle after the write.
- R3: For a vector set to rising, a 0-to-1 change on a qualified pin sets that vector's request at the clock edge where the new level is first sampled.
- R4: For a vector set to falling, a 1-to-0 change on a qualified pin sets that vector's request at the same point.
- R5: An edge of the opposite polarity to the vector's setting does not set the request.
- R6: A pin that is disabled, or that `pin_is_input` marks as not in input mode, does not set any request.
- R7: Pin p belongs to vector p / (NPINS/NVEC), so with the defaults pins 0–3 feed vector 0 and pins 4–7 feed vector 1. A qualified edge on any pin of a group sets that group's request.
- R8: A request stays set until an acknowledge pulse for its vector, and it reads 0 on the cycle after the acknowledge.
- R9: If a qualified edge and the acknowledge for the same vector arrive in the same cycle, the request stays set.
- R10: A polarity write clears every request on the next cycle, and edges seen in the cycle of that write are discarded.
- R11: Enabling a pin whose level is not changing raises no request. The previous-level sample keeps tracking each pin while it is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NPINS | Synchronized pin levels |
| pin_is_input | input | NPINS | 1 when the port has the pin in input mode |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 enables, 1 polarity |
| wr_data | input | NPINS | Write data (low NVEC bits used for polarity) |
| rd_sel | input | 1 | Read target: 0 enables, 1 polarity |
| rd_data | output | NPINS | Read data of the selected register |
| irq_ack | input | NVEC | Per-vector acknowledge pulse (vector fetch) |
| irq_req | output | NVEC | Per-vector pending request |

## Verification
The assertions assume `pin_in` is already synchronized to `clk`, so a level change is seen once and is never metastable. They also assume that acknowledges and register writes are sampled only at clock edges. They place no limit on how often an acknowledge arrives, even when no request is pending, or on how acknowledges coincide with edges and polarity writes. The stimulus changes every input a short delay after a rising edge and holds it until the next edge. The random phase toggles pins, input-mode flags, enables, polarity and acknowledges freely. It therefore produces the coincidences of edge with acknowledge and of edge with polarity write that the properties rank.

// File: rtl/pei_pkg.sv
// Package: shared selector encoding for the pin edge interrupt block.
// Assumes: a single-bit register select on both write and read paths.
package pei_pkg;
    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_RISE   = 1'b1
    } pei_sel_e;
endpackage

// File: rtl/pei_regs.sv
// Module: control registers of the pin edge interrupt block.
// Holds the per-pin enable mask and the per-vector polarity bits, and
// provides a combinational read mux. It raises a one-cycle strobe when
// the polarity bits are written so the request latches can be cleared.
// Assumes: writes are single-cycle strobes sampled on clk.
module pei_regs #(
    parameter int NPINS = 8,
    parameter int NVEC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [NPINS-1:0] wr_data,
    input  logic             rd_sel,
    output logic [NPINS-1:0] rd_data,
    output logic [NPINS-1:0] en_q,
    output logic [NVEC-1:0]  rise_q,
    output logic             rise_wr
);
    import pei_pkg::*;

    // Register updates on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            rise_q <= '0;
        end else if (wr_en) begin
            if (pei_sel_e'(wr_sel) == SEL_ENABLE) en_q   <= wr_data;
            else                                  rise_q <= wr_data[NVEC-1:0];
        end
    end

    // Strobe marking a polarity write in this cycle.
    assign rise_wr = wr_en && (pei_sel_e'(wr_sel) == SEL_RISE);

    // Read mux; polarity bits zero-extended.
    always_comb begin
        rd_data = '0;
        if (pei_sel_e'(rd_sel) == SEL_ENABLE) rd_data = en_q;
        else                                  rd_data[NVEC-1:0] = rise_q;
    end

    // R2
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (en_q == $past(wr_data)));

    // R2
    rise_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (rise_q == $past(wr_data[NVEC-1:0])));
endmodule

// File: rtl/pei_edge.sv
// Module: per-pin edge detection and per-vector grouping.
// Compares each pin with its sample from the previous cycle. The sample
// register tracks every pin whatever its enable, so enabling a pin at a
// steady level finds no edge. A qualified edge is combined by OR into
// the hit of the pin's vector; pins are grouped contiguously.
// Assumes: pin_in is synchronous to clk; NPINS is a multiple of NVEC.
module pei_edge #(
    parameter int NPINS = 8,
    parameter int NVEC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_is_input,
    input  logic [NPINS-1:0] en_q,
    input  logic [NVEC-1:0]  rise_q,
    output logic [NVEC-1:0]  vec_hit
);
    localparam int GRP = NPINS / NVEC;

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] pin_hit;

    // Previous-level sample, tracking all pins unconditionally.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_in;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        localparam int V = p / GRP;
        logic up, dn;
        // Edge of the vector's polarity, gated by enable and input mode.
        always_comb begin
            up = pin_in[p] && !prev_q[p];
            dn = !pin_in[p] && prev_q[p];
            pin_hit[p] = en_q[p] && pin_is_input[p] && (rise_q[V] ? up : dn);
        end
    end

    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        // OR of the qualified edges of the vector's group.
        assign vec_hit[v] = |pin_hit[v*GRP +: GRP];
    end
endmodule

// File: rtl/pei_latch.sv
// Module: pending request latch of one vector.
// Priority, highest first: polarity-write clear, new edge, acknowledge.
// Assumes: hit, ack and clr are sampled on clk.
module pei_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    input  logic clr,
    output logic req
);
    // Request state update.
    always_ff @(posedge clk) begin
        if (!rst_n)   req <= 1'b0;
        else if (clr) req <= 1'b0;
        else if (hit) req <= 1'b1;
        else if (ack) req <= 1'b0;
    end

    // R8
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack && !hit) |=> !req);

    // R9
    hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !clr) |=> req);

    // R10
    rise_wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !req);

    // R8
    holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !clr) |=> req);

    // R6
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !hit) |=> !req);
endmodule

// File: rtl/pin_edge_irq.sv
// Module: top of the edge-triggered pin interrupt controller.
// Wires the control registers, the edge detector and one request latch
// per vector. A polarity write clears all vectors.
// Assumes: pin_in synchronized upstream; NPINS a multiple of NVEC.
module pin_edge_irq #(
    parameter int NPINS = 8,
    parameter int NVEC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pin_is_input,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [NPINS-1:0] wr_data,
    input  logic             rd_sel,
    output logic [NPINS-1:0] rd_data,
    input  logic [NVEC-1:0]  irq_ack,
    output logic [NVEC-1:0]  irq_req
);
    logic [NPINS-1:0] en_q;
    logic [NVEC-1:0]  rise_q;
    logic             rise_wr;
    logic [NVEC-1:0]  vec_hit;

    pei_regs #(.NPINS(NPINS), .NVEC(NVEC)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .en_q(en_q), .rise_q(rise_q), .rise_wr(rise_wr)
    );

    pei_edge #(.NPINS(NPINS), .NVEC(NVEC)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pin_is_input(pin_is_input), .en_q(en_q), .rise_q(rise_q),
        .vec_hit(vec_hit)
    );

    for (genvar v = 0; v < NVEC; v++) begin : g_latch
        pei_latch u_latch (
            .clk(clk), .rst_n(rst_n), .hit(vec_hit[v]),
            .ack(irq_ack[v]), .clr(rise_wr), .req(irq_req[v])
        );
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_req == '0));
endmodule

// File: tb/pin_edge_irq_test.sv
module pin_edge_irq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NV = 2;
    localparam int GRP = NP / NV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0] pin = '0, inm = '1, wr_data = '0, rd_data;
    logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [NV-1:0] ack = '0, irq;

    int checks = 0, fails = 0;
    logic [NP-1:0] m_prev, m_en;
    logic [NV-1:0] m_rise, m_req;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_edge_irq #(.NPINS(NP), .NVEC(NV)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin), .pin_is_input(inm),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_ack(ack), .irq_req(irq)
    );

    function automatic logic [NV-1:0] vec_hits(logic [NP-1:0] p, pr, en, im,
                                               logic [NV-1:0] rs);
        logic [NV-1:0] h = '0;
        for (int i = 0; i < NP; i++) begin
            logic e = rs[i/GRP] ? (p[i] && !pr[i]) : (!p[i] && pr[i]);
            if (e && en[i] && im[i]) h[i/GRP] = 1'b1;
        end
        return h;
    endfunction

    function automatic logic [NP-1:0] exp_rd(logic s, logic [NP-1:0] en,
                                             logic [NV-1:0] rs);
        logic [NP-1:0] r = '0;
        if (s) r[NV-1:0] = rs; else r = en;
        return r;
    endfunction

    task automatic chk(input logic [31:0] act, exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: model next state, advance, compare outputs with the model.
    task automatic step(input string tag);
        logic [NV-1:0] h = vec_hits(pin, m_prev, m_en, inm, m_rise);
        logic clr = wr_en && wr_sel;
        logic [NV-1:0] nr;
        for (int v = 0; v < NV; v++)
            nr[v] = clr ? 1'b0 : h[v] ? 1'b1 : ack[v] ? 1'b0 : m_req[v];
        @(posedge clk); #1;
        m_prev = pin;
        if (wr_en) begin
            if (wr_sel) m_rise = wr_data[NV-1:0]; else m_en = wr_data;
        end
        m_req = nr;
        wr_en = 1'b0; ack = '0;
        chk(32'(irq), 32'(m_req), tag);
        chk(32'(rd_data), 32'(exp_rd(rd_sel, m_en, m_rise)), "R2");
    endtask

    task automatic wr(input logic s, input logic [NP-1:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        m_prev = '0; m_en = '0; m_rise = '0; m_req = '0;
        // R1: reset state
        chk(32'(irq), 0, "R1");
        rd_sel = 1'b0; #1; chk(32'(rd_data), 0, "R1");
        rd_sel = 1'b1; #1; chk(32'(rd_data), 0, "R1");
        rst_n = 1'b1;
        step("R1");
        // R2: register write and readback
        wr(1'b0, 8'hA5); rd_sel = 1'b0; step("R2");
        chk(32'(rd_data), 32'h A5, "R2");
        wr(1'b1, 8'h01); rd_sel = 1'b1; step("R2");
        chk(32'(rd_data), 32'h01, "R2");
        // vector 0 rising, vector 1 falling, all enabled
        wr(1'b0, 8'hFF); step("R2");
        pin[1] = 1'b1; step("R3"); chk(32'(irq), 32'h1, "R3 R7 rising pin1 vec0");
        step("R8"); chk(32'(irq), 32'h1, "R8 hold");
        ack[0] = 1'b1; step("R8"); chk(32'(irq), 0, "R8 ack clears");
        pin[5] = 1'b1; step("R5"); chk(32'(irq), 0, "R5 opposite edge");
        pin[5] = 1'b0; step("R4"); chk(32'(irq), 32'h2, "R4 R7 falling pin5 vec1");
        ack[1] = 1'b1; step("R8"); chk(32'(irq), 0, "R8 ack vec1");
        // R6: disabled pin and output-mode pin
        wr(1'b0, 8'hFE); step("R6");
        pin[0] = 1'b1; step("R6"); chk(32'(irq), 0, "R6 disabled pin");
        inm[2] = 1'b0; pin[2] = 1'b1; step("R6"); chk(32'(irq), 0, "R6 output mode");
        inm[2] = 1'b1;
        // R9: edge and ack together
        pin[3] = 1'b1; ack[0] = 1'b1; step("R9"); chk(32'(irq), 32'h1, "R9 edge wins");
        ack[0] = 1'b1; step("R8");
        // R10: polarity write clears all
        pin[1] = 1'b0; step("R10");
        pin[1] = 1'b1; step("R10");
        pin[6] = 1'b1; step("R10");
        pin[6] = 1'b0; step("R10"); chk(32'(irq), 32'h3, "R7 both vectors");
        wr(1'b1, 8'h01); step("R10"); chk(32'(irq), 0, "R10 clear");
        pin[1] = 1'b0; step("R10");
        pin[1] = 1'b1; wr(1'b1, 8'h01); step("R10"); chk(32'(irq), 0, "R10 edge discarded");
        // R11: enable with static level
        wr(1'b0, 8'h00); step("R11");
        pin[0] = 1'b0; step("R11");
        pin[0] = 1'b1; step("R11");
        step("R11");
        wr(1'b0, 8'hFF); step("R11");
        step("R11"); chk(32'(irq), 0, "R11 no spurious");
        // Random phase with fixed seed
        void'($urandom(1234));
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NP; i++) if ($urandom_range(7) == 0) pin[i] = ~pin[i];
            if ($urandom_range(15) == 0) inm = NP'($urandom);
            if ($urandom_range(11) == 0) wr(1'($urandom), NP'($urandom));
            ack = NV'($urandom) & NV'($urandom);
            rd_sel = 1'($urandom);
            step("R7 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule